// File: doc/BRIEF.md
# Address Entry Allocation Search Engine

This block chooses where a MAC/VLAN address entry should be written in a switch lookup table. A command supplies a 48-bit MAC address, a 12-bit VLAN ID and a flag saying whether the entry is VLAN-qualified. The engine reads the table through a synchronous-read RAM port, one entry per clock, and decodes the fields of each word as it arrives.

It tracks three kinds of candidate during that one pass. The first is an existing entry holding the same address. The second is the lowest free slot. The third is the lowest unicast entry that may be aged out. An existing match wins over the other two, even when it lies above a free slot, and finding one ends the scan early. With no candidate of any kind, the engine reports that the table is full. Writing the chosen entry back is done by separate logic.

The state machine has four states. ST_IDLE waits for `start_i`; a start captures the key and clears the candidates. ST_SCAN issues one read per cycle. It moves to ST_DONE as soon as a returned word matches, or to ST_DRAIN once the last address has been issued. ST_DRAIN evaluates the last returned word and always moves to ST_DONE. ST_DONE raises `done_o` for one cycle and returns to ST_IDLE.

Top module: `ase_alloc_search`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `found_o`, `free_o`, `full_o` and `mem_rd_o` are all 0.
- R2: A start accepted in ST_IDLE raises `busy_o` on the next cycle. While scanning, `mem_rd_o` is high and `mem_addr_o` counts up from 0 by one per cycle.
- R3: Each 64-bit entry word is decoded as follows: bits 63:62 hold the unicast type, bits 61:60 the kind (0 free, 1 address, 2 VLAN, 3 VLAN plus address), bits 59:48 the VLAN ID, and bits 47:0 the MAC (byte 0 at 47:40, byte 5 at 7:0). An entry matches only when its kind is 1 or 3, its VLAN ID equals the requested one, and its 48 MAC bits are equal to the requested MAC.
- R4: When `vlan_q_i` is 0, the requested VLAN ID is taken as 0 and `vid_i` is ignored.
- R5: When a match exists, the result is the matching index with `found_o`=1, `free_o`=0 and `full_o`=0. This holds even if a free slot lies at a lower index.
- R6: With no match, the result is the lowest index of kind 0, with `free_o`=1, `found_o`=0 and `full_o`=0.
- R7: With no match and no free slot, the result is the lowest entry of kind 1 or 3 whose bit 40 (multicast) is 0 and whose unicast type is 1 or 3. In this case `found_o`, `free_o` and `full_o` are all 0.
- R8: With no candidate of any kind, `full_o`=1 and both `found_o` and `free_o` are 0.
- R9: `done_o` is a single-cycle pulse and is never high together with `busy_o`. When the match is at index m, `done_o` rises m+2 clock edges after the start edge; otherwise it rises DEPTH+1 edges after the start edge.
- R10: The result index and flags stay unchanged after `done_o` until the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a search when the engine is idle |
| mac_i | input | 48 | Requested MAC address |
| vid_i | input | 12 | Requested VLAN ID |
| vlan_q_i | input | 1 | Command is VLAN-qualified |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle completion pulse |
| idx_o | output | IDX_W | Chosen table index |
| found_o | output | 1 | Result is an existing matching entry |
| free_o | output | 1 | Result is a free slot |
| full_o | output | 1 | No usable slot exists |
| mem_rd_o | output | 1 | Table read enable |
| mem_addr_o | output | IDX_W | Table read address |
| mem_data_i | input | 64 | Table word, valid one cycle after a read |

## Verification
The bench builds the engine with DEPTH=8, so every scan ends within ten cycles. An eight-word table model holds every entry kind together with persistent, OUI, ageable and multicast entries. With that table, the exact early-stop latency m+2 and the full-scan latency DEPTH+1 can both be checked. Step by step, the bench removes the free slots and then the ageable entries, which reaches the ageable-only result and the table-full result with only a few rewrites.

// File: rtl/ase_pkg.sv
package ase_pkg;

    localparam int MAC_W = 48;
    localparam int VID_W = 12;

    localparam logic [1:0] KIND_FREE  = 2'd0;
    localparam logic [1:0] KIND_ADDR  = 2'd1;
    localparam logic [1:0] KIND_VLAN  = 2'd2;
    localparam logic [1:0] KIND_VADDR = 2'd3;

    localparam logic [1:0] UT_PERSIST = 2'd0;
    localparam logic [1:0] UT_OUI     = 2'd2;

    // bit positions follow the stored table format
    typedef struct packed {
        logic [1:0]       ucast;
        logic [1:0]       kind;
        logic [VID_W-1:0] vid;
        logic [MAC_W-1:0] mac;
    } entry_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_DRAIN,
        ST_DONE
    } scan_state_e;

    localparam int CAND_MATCH = 0;
    localparam int CAND_FREE  = 1;
    localparam int CAND_AGE   = 2;
    localparam int CAND_N     = 3;

endpackage

// File: rtl/ase_entry_classify.sv
module ase_entry_classify
    import ase_pkg::*;
(
    input  logic [63:0]      word_i,
    input  logic [MAC_W-1:0] key_mac_i,
    input  logic [VID_W-1:0] key_vid_i,
    output logic             is_match_o,
    output logic             is_free_o,
    output logic             is_ageable_o
);
    entry_t ent;
    logic   addr_kind;

    always_comb begin
        ent          = entry_t'(word_i);
        addr_kind    = (ent.kind == KIND_ADDR) || (ent.kind == KIND_VADDR);
        is_match_o   = addr_kind && (ent.vid == key_vid_i) && (ent.mac == key_mac_i);
        is_free_o    = (ent.kind == KIND_FREE);
        is_ageable_o = addr_kind && !ent.mac[40] &&
                       (ent.ucast != UT_PERSIST) && (ent.ucast != UT_OUI);
    end
endmodule

// File: rtl/ase_candidate.sv
module ase_candidate #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             hit_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             have_o,
    output logic [IDX_W-1:0] idx_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_o <= 1'b0;
            idx_o  <= '0;
        end else if (clear_i) begin
            have_o <= 1'b0;
            idx_o  <= '0;
        end else if (hit_i && !have_o) begin
            have_o <= 1'b1;
            idx_o  <= idx_i;
        end
    end

    // the first (lowest) index seen is kept for the rest of the scan
    assert_first_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (have_o && !clear_i) |=> (have_o && $stable(idx_o)));
endmodule

// File: rtl/ase_scan_fsm.sv
module ase_scan_fsm
    import ase_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             match_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             clear_o,
    output logic             eval_o,
    output logic [IDX_W-1:0] eval_idx_o,
    output logic             rd_o,
    output logic [IDX_W-1:0] rd_addr_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    scan_state_e state_q, state_d;
    logic [IDX_W-1:0] cnt_q;
    logic             pend_q;
    logic [IDX_W-1:0] pend_idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            pend_q     <= 1'b0;
            pend_idx_q <= '0;
        end else begin
            state_q    <= state_d;
            pend_q     <= (state_q == ST_SCAN);
            pend_idx_q <= cnt_q;
            if (clear_o)
                cnt_q <= '0;
            else if (state_q == ST_SCAN && cnt_q != LAST)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_SCAN;
            ST_SCAN: begin
                if (pend_q && match_i)  state_d = ST_DONE;
                else if (cnt_q == LAST) state_d = ST_DRAIN;
            end
            ST_DRAIN: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy_o     = (state_q == ST_SCAN) || (state_q == ST_DRAIN);
        done_o     = (state_q == ST_DONE);
        clear_o    = (state_q == ST_IDLE) && start_i;
        rd_o       = (state_q == ST_SCAN);
        rd_addr_o  = cnt_q;
        eval_o     = pend_q && busy_o;
        eval_idx_o = pend_idx_q;
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o));
    assert_read_in_scan_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_o |-> busy_o);
    assert_addr_ascends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_o && $past(rd_o)) |-> (rd_addr_o == $past(rd_addr_o) + 1'b1));
endmodule

// File: rtl/ase_alloc_search.sv
module ase_alloc_search
    import ase_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [47:0]      mac_i,
    input  logic [11:0]      vid_i,
    input  logic             vlan_q_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             found_o,
    output logic             free_o,
    output logic             full_o,
    output logic             mem_rd_o,
    output logic [IDX_W-1:0] mem_addr_o,
    input  logic [63:0]      mem_data_i
);
    logic             clear, eval;
    logic [IDX_W-1:0] eval_idx;
    logic [MAC_W-1:0] key_mac_q;
    logic [VID_W-1:0] key_vid_q;
    logic             held_q;
    logic             c_match, c_free, c_age;
    logic [CAND_N-1:0] hit, have;
    logic [IDX_W-1:0] cidx [CAND_N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_mac_q <= '0;
            key_vid_q <= '0;
            held_q    <= 1'b0;
        end else begin
            if (clear) begin
                key_mac_q <= mac_i;
                key_vid_q <= vlan_q_i ? vid_i : '0;
            end
            if (clear)       held_q <= 1'b0;
            else if (done_o) held_q <= 1'b1;
        end
    end

    ase_scan_fsm #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .match_i    (c_match),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .clear_o    (clear),
        .eval_o     (eval),
        .eval_idx_o (eval_idx),
        .rd_o       (mem_rd_o),
        .rd_addr_o  (mem_addr_o)
    );

    ase_entry_classify u_cls (
        .word_i       (mem_data_i),
        .key_mac_i    (key_mac_q),
        .key_vid_i    (key_vid_q),
        .is_match_o   (c_match),
        .is_free_o    (c_free),
        .is_ageable_o (c_age)
    );

    assign hit[CAND_MATCH] = eval && c_match;
    assign hit[CAND_FREE]  = eval && c_free;
    assign hit[CAND_AGE]   = eval && c_age;

    for (genvar g = 0; g < CAND_N; g++) begin : g_cand
        ase_candidate #(.IDX_W(IDX_W)) u_cand (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear_i (clear),
            .hit_i   (hit[g]),
            .idx_i   (eval_idx),
            .have_o  (have[g]),
            .idx_o   (cidx[g])
        );
    end

    logic res_ok;
    always_comb begin
        res_ok  = done_o || held_q;
        found_o = res_ok && have[CAND_MATCH];
        free_o  = res_ok && !have[CAND_MATCH] && have[CAND_FREE];
        full_o  = res_ok && (have == '0);
        if (!res_ok)                idx_o = '0;
        else if (have[CAND_MATCH])  idx_o = cidx[CAND_MATCH];
        else if (have[CAND_FREE])   idx_o = cidx[CAND_FREE];
        else                        idx_o = cidx[CAND_AGE];
    end

    assert_full_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> (!found_o && !free_o));
    assert_result_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(idx_o) && $stable(full_o) && $stable(found_o)));
    assert_match_ends_scan_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && c_match && mem_rd_o) |=> done_o);
endmodule

// File: tb/ase_alloc_search_tb.sv
module ase_alloc_search_tb;
    localparam int DEPTH = 8;
    localparam int IDX_W = 3;

    typedef struct packed {
        logic [47:0] mac;
        logic [11:0] vid;
        logic        vq;
        logic [1:0]  kind;   // 0 match, 1 free, 2 ageable, 3 full
        logic [2:0]  idx;
    } vec_t;

    localparam logic [47:0] MA = 48'h0200_0000_00A1;
    localparam logic [47:0] MB = 48'h0400_0000_00B2;
    localparam logic [47:0] MC = 48'h0600_0000_00C3;
    localparam logic [47:0] MD = 48'h0100_5E00_0001;
    localparam logic [47:0] ME = 48'h0800_0000_00E4;
    localparam logic [47:0] MF = 48'h0A00_0000_00F5;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{MA, 12'd0, 1'b0, 2'd0, 3'd1},   // R3 plain address match
        '{MA, 12'd9, 1'b1, 2'd0, 3'd5},   // R5 match above free slot
        '{MA, 12'd5, 1'b1, 2'd1, 3'd3},   // R6 vid mismatch -> free
        '{MB, 12'd7, 1'b0, 2'd1, 3'd3},   // R4 vid ignored, 0 used
        '{MB, 12'd7, 1'b1, 2'd0, 3'd2},   // R3 vlan address match
        '{MD, 12'd3, 1'b0, 2'd0, 3'd7},   // R4 multicast entry match
        '{MA, 12'd0, 1'b1, 2'd0, 3'd1},   // R3 qualified vid 0
        '{ME, 12'd5, 1'b1, 2'd1, 3'd3}    // R3 VLAN kind never matches
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [47:0] mac_i = '0;
    logic [11:0] vid_i = '0;
    logic vlan_q_i = 1'b0;
    logic busy_o, done_o, found_o, free_o, full_o, mem_rd_o;
    logic [IDX_W-1:0] idx_o, mem_addr_o;
    logic [63:0] mem_data;
    logic [63:0] mem [DEPTH];
    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    always @(posedge clk) if (mem_rd_o) mem_data <= mem[mem_addr_o];

    ase_alloc_search #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mac_i(mac_i),
        .vid_i(vid_i), .vlan_q_i(vlan_q_i), .busy_o(busy_o), .done_o(done_o),
        .idx_o(idx_o), .found_o(found_o), .free_o(free_o), .full_o(full_o),
        .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_data_i(mem_data)
    );

    function automatic logic [63:0] mk(input logic [1:0] ut, input logic [1:0] kind,
                                       input logic [11:0] vid, input logic [47:0] mac);
        return {ut, kind, vid, mac};
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input vec_t v);
        int n;
        logic addr_ok;
        int kact;
        int lat;
        @(negedge clk);
        mac_i = v.mac; vid_i = v.vid; vlan_q_i = v.vq; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o === 1'b1, "R2 busy after start", int'(busy_o), 1);
        n = 0;
        addr_ok = 1'b1;
        while (!done_o && n < 40) begin
            if (mem_rd_o && mem_addr_o != IDX_W'(n)) addr_ok = 1'b0;
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        chk(addr_ok, "R2 ascending read addresses", int'(addr_ok), 1);
        lat = (v.kind == 2'd0) ? int'(v.idx) + 2 : DEPTH + 1;
        chk(n == lat, "R9 done latency", n, lat);
        kact = found_o ? 0 : free_o ? 1 : full_o ? 3 : 2;
        chk(kact == int'(v.kind) && (int'(found_o) + int'(free_o) + int'(full_o)) <= 1,
            (v.kind == 0) ? "R5 match result" : (v.kind == 1) ? "R6 free result" :
            (v.kind == 2) ? "R7 ageable result" : "R8 full result", kact, int'(v.kind));
        if (v.kind != 2'd3)
            chk(idx_o == v.idx, "R5 R6 R7 result index", int'(idx_o), int'(v.idx));
        chk(!busy_o, "R9 busy low with done", int'(busy_o), 0);
        @(negedge clk);
        chk(!done_o, "R9 done single pulse", int'(done_o), 0);
    endtask

    initial begin
        #(200000 * 8);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        mem[0] = mk(2'd0, 2'd2, 12'd5, ME);
        mem[1] = mk(2'd0, 2'd1, 12'd0, MA);
        mem[2] = mk(2'd1, 2'd3, 12'd7, MB);
        mem[3] = mk(2'd0, 2'd0, 12'd0, 48'h0);
        mem[4] = mk(2'd2, 2'd1, 12'd0, MC);
        mem[5] = mk(2'd3, 2'd3, 12'd9, MA);
        mem[6] = mk(2'd0, 2'd0, 12'd0, 48'h0);
        mem[7] = mk(2'd3, 2'd1, 12'd0, MD);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({busy_o, done_o, found_o, free_o, full_o, mem_rd_o} == 6'b0,
            "R1 outputs in reset", int'({busy_o, done_o, found_o, free_o, full_o, mem_rd_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy_o, done_o, found_o, free_o, full_o, mem_rd_o} == 6'b0,
            "R1 idle after reset", int'({busy_o, done_o, found_o, free_o, full_o, mem_rd_o}), 0);

        for (int i = 0; i < NV; i++) run(VECS[i]);

        // R10 result held over idle cycles
        begin
            logic [IDX_W-1:0] hi;
            logic [2:0] hf;
            hi = idx_o; hf = {found_o, free_o, full_o};
            repeat (4) @(negedge clk);
            chk(idx_o == hi && {found_o, free_o, full_o} == hf, "R10 result held",
                int'(idx_o), int'(hi));
        end

        // R7 no free slots left -> lowest ageable unicast
        mem[3] = mk(2'd0, 2'd2, 12'd1, 48'h0);
        mem[6] = mk(2'd0, 2'd2, 12'd2, 48'h0);
        run('{MF, 12'd0, 1'b0, 2'd2, 3'd2});
        // R7 persistent entry skipped, next ageable chosen
        mem[2] = mk(2'd0, 2'd3, 12'd7, MB);
        run('{MF, 12'd0, 1'b0, 2'd2, 3'd5});
        // R8 OUI, persistent and multicast only -> full
        mem[5] = mk(2'd2, 2'd3, 12'd9, MA);
        run('{MF, 12'd0, 1'b0, 2'd3, 3'd0});
        // R5 match still found in a full table, at the last index
        run('{MD, 12'd0, 1'b0, 2'd0, 3'd7});

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule